// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with Latched Level Interrupts

The block is a register-mapped general-purpose I/O unit for twelve pins. Software writes an output value and a per-pin drive enable, reads back the pin levels through a two-stage synchronizer, and chooses, per pin, whether a high or a low level counts as an interrupt request. Requests are caught in a sticky status register that software clears by writing ones. A per-pin enable mask decides which caught requests reach the single interrupt output.

The status register latches level, not edges. While a pin stays at its active level its status bit cannot be cleared: the clear is overridden in the same cycle and the interrupt stays asserted until the source goes away. Polarity selects sit one every four bits in two type registers, the low eight pins in one and the upper four in the other. A 32-bit mux control register is kept as plain storage for logic outside the block.

Top module: `gpio_li_ctrl`

## Requirements
- R1: After reset every register holds zero, `pad_out_o`, `pad_oe_o` and `bus_rdata_o` are zero and `irq_o` is low.
- R2: Offset 0x00 bits [11:0] set `pad_out_o`, and offset 0x04 bits [11:0] set `pad_oe_o`. A 1 in the enable bit means the pin is driven. Both read back.
- R3: Offset 0x08 reads the pins after two synchronizing flops, in bits [11:0], whatever the drive enables hold. Writes to it are ignored.
- R4: The polarity of pin n (n < 8) is bit 4n of offset 0x10. The polarity of pin n (n >= 8) is bit 4(n-8) of offset 0x18. Polarity 0 means active-high and 1 means active-low.
- R5: Status bit n at offset 0x0C sets in the clock after the synchronized pin n is at its active level, whatever the enable mask holds. Writing 1 to a bit clears it and writing 0 leaves it unchanged.
- R6: A clear of a status bit whose synchronized pin is still active in that cycle has no effect, and the bit stays set.
- R7: Offset 0x14 bits [11:0] form the interrupt enable mask. `irq_o` is the OR over all pins of (status AND enable).
- R8: Offset 0x1C is a 32-bit read/write register.
- R9: Bits outside the pin bits and the polarity bits read as zero and ignore writes. Unmapped byte addresses read zero and their writes have no effect.
- R10: `bus_rdata_o` loads the addressed register at a clock edge where `bus_rd_i` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 5 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pad_in_i | input | 12 | Pin levels, asynchronous |
| pad_out_o | output | 12 | Output value to pads |
| pad_oe_o | output | 12 | Per-pin drive enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a status clear that lands while its pin is still active. It only shows up when the polarity setting, the pin level, the two synchronizer stages and a write of ones all line up in one cycle. A directed sequence sets one upper pin to active-low, leaves the pin low, enables it and clears it. It then releases the pin and counts off the synchronizer delay before clearing again. Random traffic with pins that toggle seldom then hits clears against both active and released pins many more times, with and without the mask bit set.

// File: rtl/gpio_li_pkg.sv
package gpio_li_pkg;
  parameter int POL_STRIDE  = 4;
  parameter int POL_PER_REG = 8;

  parameter logic [7:0] OFF_DOUT = 8'h00;
  parameter logic [7:0] OFF_OE   = 8'h04;
  parameter logic [7:0] OFF_DIN  = 8'h08;
  parameter logic [7:0] OFF_STAT = 8'h0C;
  parameter logic [7:0] OFF_TYP0 = 8'h10;
  parameter logic [7:0] OFF_IEN  = 8'h14;
  parameter logic [7:0] OFF_TYP1 = 8'h18;
  parameter logic [7:0] OFF_MUX  = 8'h1C;

  // writable polarity bits for a type register serving cnt pins
  function automatic logic [31:0] pol_mask(int cnt);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++)
      if ((i % POL_STRIDE) == 0 && (i / POL_STRIDE) < cnt) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpio_li_sync.sv
module gpio_li_sync #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_li_irq.sv
module gpio_li_irq
  import gpio_li_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int DW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic [DW-1:0]    type0_i,
  input  logic [DW-1:0]    type1_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] en_i,
  output logic [NPINS-1:0] status_o,
  output logic             irq_o
);
  logic [NPINS-1:0] pol, active, status_q;

  for (genvar n = 0; n < NPINS; n++) begin : g_pol
    if (n < POL_PER_REG) begin : g_lo
      assign pol[n] = type0_i[POL_STRIDE*n];
    end else begin : g_hi
      assign pol[n] = type1_i[POL_STRIDE*(n-POL_PER_REG)];
    end
  end

  assign active = pin_i ^ pol;

  // set wins over clear: a level still present re-latches at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_i) | active;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & en_i);

  p_clear_blocked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(active)) == $past(active)));

  p_w1c_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_q) & ~status_q & ~$past(clr_i)) == '0));

  p_set_needs_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(active)) == '0));
endmodule

// File: rtl/gpio_li_ctrl.sv
module gpio_li_ctrl
  import gpio_li_pkg::*;
#(
  parameter int NPINS = 12,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [NPINS-1:0] pad_in_i,
  output logic [NPINS-1:0] pad_out_o,
  output logic [NPINS-1:0] pad_oe_o,
  output logic             irq_o
);
  localparam int LO_PINS = (NPINS < POL_PER_REG) ? NPINS : POL_PER_REG;
  localparam int HI_PINS = (NPINS > POL_PER_REG) ? NPINS - POL_PER_REG : 0;
  localparam logic [DW-1:0] T0_MASK = DW'(pol_mask(LO_PINS));
  localparam logic [DW-1:0] T1_MASK = DW'(pol_mask(HI_PINS));

  localparam logic [AW-1:0] A_DOUT = AW'(OFF_DOUT);
  localparam logic [AW-1:0] A_OE   = AW'(OFF_OE);
  localparam logic [AW-1:0] A_DIN  = AW'(OFF_DIN);
  localparam logic [AW-1:0] A_STAT = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_TYP0 = AW'(OFF_TYP0);
  localparam logic [AW-1:0] A_IEN  = AW'(OFF_IEN);
  localparam logic [AW-1:0] A_TYP1 = AW'(OFF_TYP1);
  localparam logic [AW-1:0] A_MUX  = AW'(OFF_MUX);

  logic [NPINS-1:0] dout_q, oe_q, en_q, pin_sync, status, clr;
  logic [DW-1:0]    type0_q, type1_q, mux_q, rdata_q, rd_mux;

  gpio_li_sync #(.W(NPINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pin_sync)
  );

  assign clr = (bus_wr_i && bus_addr_i == A_STAT) ? bus_wdata_i[NPINS-1:0] : '0;

  gpio_li_irq #(.NPINS(NPINS), .DW(DW)) i_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_i    (pin_sync),
    .type0_i  (type0_q),
    .type1_i  (type1_q),
    .clr_i    (clr),
    .en_i     (en_q),
    .status_o (status),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q  <= '0;
      oe_q    <= '0;
      en_q    <= '0;
      type0_q <= '0;
      type1_q <= '0;
      mux_q   <= '0;
    end else if (bus_wr_i) begin
      unique case (bus_addr_i)
        A_DOUT:  dout_q  <= bus_wdata_i[NPINS-1:0];
        A_OE:    oe_q    <= bus_wdata_i[NPINS-1:0];
        A_IEN:   en_q    <= bus_wdata_i[NPINS-1:0];
        A_TYP0:  type0_q <= bus_wdata_i & T0_MASK;
        A_TYP1:  type1_q <= bus_wdata_i & T1_MASK;
        A_MUX:   mux_q   <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      A_DOUT:  rd_mux = DW'(dout_q);
      A_OE:    rd_mux = DW'(oe_q);
      A_DIN:   rd_mux = DW'(pin_sync);
      A_STAT:  rd_mux = DW'(status);
      A_TYP0:  rd_mux = type0_q;
      A_IEN:   rd_mux = DW'(en_q);
      A_TYP1:  rd_mux = type1_q;
      A_MUX:   rd_mux = mux_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign pad_out_o   = dout_q;
  assign pad_oe_o    = oe_q;

  p_oe_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == A_OE) |=> $stable(pad_oe_o));

  p_mask_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);

  p_rd_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |=> $stable(bus_rdata_o));

  p_din_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == A_DIN) |=> (bus_rdata_o[DW-1:NPINS] == '0));
endmodule

// File: tb/test_gpio_li_ctrl.sv
module test_gpio_li_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 12;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NP-1:0] pad_v = '0, pad_out, pad_oe;
  logic        irq;

  int n_cmp = 0, n_bad = 0;

  // reference state
  logic [NP-1:0] m_out, m_oe, m_en, m_st, m_s1, m_s2;
  logic [31:0]   m_t0, m_t1, m_mux, m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_li_ctrl i_gpio_li_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_v), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  function automatic logic [NP-1:0] exp_active();
    logic [NP-1:0] a;
    for (int n = 0; n < NP; n++)
      a[n] = m_s2[n] ^ (n < 8 ? m_t0[4*n] : m_t1[4*(n-8)]);
    return a;
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    case (a)
      5'h00: return 32'(m_out);
      5'h04: return 32'(m_oe);
      5'h08: return 32'(m_s2);
      5'h0C: return 32'(m_st);
      5'h10: return m_t0;
      5'h14: return 32'(m_en);
      5'h18: return m_t1;
      5'h1C: return m_mux;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_out = '0; m_oe = '0; m_en = '0; m_st = '0; m_s1 = '0; m_s2 = '0;
    m_t0 = '0; m_t1 = '0; m_mux = '0; m_rd = '0;
  endtask

  task automatic model_step(logic w, logic r, logic [4:0] a, logic [31:0] d);
    logic [NP-1:0] act, clr;
    act = exp_active();
    clr = (w && a == 5'h0C) ? d[NP-1:0] : '0;
    if (r) m_rd = exp_read(a);
    m_st = (m_st & ~clr) | act;
    if (w) begin
      case (a)
        5'h00: m_out = d[NP-1:0];
        5'h04: m_oe  = d[NP-1:0];
        5'h10: m_t0  = d & 32'h1111_1111;
        5'h14: m_en  = d[NP-1:0];
        5'h18: m_t1  = d & 32'h0000_1111;
        5'h1C: m_mux = d;
        default: ;
      endcase
    end
    m_s2 = m_s1;
    m_s1 = pad_v;
  endtask

  task automatic step(logic w, logic r, logic [4:0] a, logic [31:0] d);
    wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    model_step(w, r, a, d);
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " rdata"}, rdata, m_rd);
    chk({req, " irq"}, 32'(irq), 32'(|(m_st & m_en)));
    chk({req, " pad_out"}, 32'(pad_out), 32'(m_out));
    chk({req, " pad_oe"}, 32'(pad_oe), 32'(m_oe));
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    step(1'b0, 1'b1, a, 32'h0);
    chk(req, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] a;
    void'($urandom(32'd7531));
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 pad_out", 32'(pad_out), 32'h0);
    chk("R1 pad_oe", 32'(pad_oe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) rd_chk("R1 reg zero", 5'(4*i), 32'h0);

    // R2 outputs, R9 unused bits
    step(1'b1, 1'b0, 5'h00, 32'hFFFF_FABC);
    step(1'b1, 1'b0, 5'h04, 32'h0000_00F0);
    chk("R2 pad_out", 32'(pad_out), 32'h0000_0ABC);
    chk("R2 pad_oe", 32'(pad_oe), 32'h0000_00F0);
    rd_chk("R9 dout upper zero", 5'h00, 32'h0000_0ABC);
    step(1'b1, 1'b0, 5'h10, 32'hFFFF_FFFF);
    rd_chk("R9 type0 mask", 5'h10, 32'h1111_1111);
    step(1'b1, 1'b0, 5'h10, 32'h0);
    step(1'b1, 1'b0, 5'h1C, 32'hDEAD_BEEF);
    rd_chk("R8 mux", 5'h1C, 32'hDEAD_BEEF);
    step(1'b1, 1'b0, 5'h02, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped read", 5'h02, 32'h0);
    rd_chk("R9 unmapped write no effect", 5'h00, 32'h0000_0ABC);

    // R3 input sync, independent of drive enables, writes ignored
    pad_v = 12'h0A5;
    step(1'b1, 1'b0, 5'h08, 32'hFFF);
    step(1'b0, 1'b0, 5'h0, 32'h0);
    rd_chk("R3 din", 5'h08, 32'h0000_00A5);
    // pins 0,2,5,7 active-high now latched
    step(1'b1, 1'b0, 5'h0C, 32'hFFF);
    pad_v = 12'h000;
    repeat (3) step(1'b0, 1'b0, 5'h0, 32'h0);
    step(1'b1, 1'b0, 5'h0C, 32'hFFF);
    rd_chk("R5 cleared after release", 5'h0C, 32'h0);

    // R4 pin 9 active-low via bit 4 of 0x18
    step(1'b1, 1'b0, 5'h18, 32'h0000_0010);
    step(1'b0, 1'b0, 5'h0, 32'h0);
    rd_chk("R4 pin9 active-low", 5'h0C, 32'h0000_0200);
    chk("R7 masked no irq", 32'(irq), 32'h0);
    step(1'b1, 1'b0, 5'h14, 32'h0000_0200);
    chk("R7 irq on unmask", 32'(irq), 32'h1);
    step(1'b1, 1'b0, 5'h0C, 32'h0000_0200);
    rd_chk("R6 clear blocked", 5'h0C, 32'h0000_0200);
    chk("R6 irq stays", 32'(irq), 32'h1);
    pad_v = 12'h200;
    repeat (3) step(1'b0, 1'b0, 5'h0, 32'h0);
    step(1'b1, 1'b0, 5'h0C, 32'h0000_0000);
    rd_chk("R5 write zero keeps", 5'h0C, 32'h0000_0200);
    step(1'b1, 1'b0, 5'h0C, 32'h0000_0200);
    chk("R7 irq drops", 32'(irq), 32'h0);
    rd_chk("R5 write one clears", 5'h0C, 32'h0);
    step(1'b0, 1'b0, 5'h0, 32'h0);
    chk("R10 rdata holds", rdata, 32'h0);
    chk_all("R2 R7 model");

    // random traffic against the reference model
    for (int i = 0; i < 1500; i++) begin
      if ($urandom_range(0, 3) == 0) pad_v = NP'($urandom);
      a = ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'(4 * $urandom_range(0, 7));
      step(1'($urandom), 1'($urandom), a, $urandom);
      chk_all("R3 R4 R5 R6 R7 R8 R9 R10 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule